// File: doc/BRIEF.md
# Channel Request Status and Enable Controller

This block keeps the request state for every channel of a multi-channel timer coprocessor. Each channel can raise a host interrupt request and a data-transfer request. The channel engine raises either one with a single-cycle set pulse. Each request type has its own enable bit on every channel, and a request reaches its output line only while that enable is 1. Once raised, a request stays pending until something clears it.

Only the host and the DMA side can clear a request. The host works through a simple register bus and clears status bits by writing ones. The DMA side clears a channel's data-transfer request with that channel's completion acknowledge. The same status and enable bits appear in two views. The per-type view has one word per request type, with one bit per channel. The per-channel view has one word per channel holding that channel's four bits. A host can therefore serve requests channel by channel or in bundles. A module-disable input stops the engine from raising new requests, but both clear paths keep working while it is asserted.

Top module: `irq_dma_req_unit`

## Requirements
- R1: After reset, all status bits, enable bits, both output line vectors and the read-data port are 0.
- R2: A set pulse on channel c while module-disable is low sets that channel's status bit of that type at the next clock edge. The bit then stays 1 until it is cleared. The host has no way to set a status bit.
- R3: For each type, output line bit c equals status bit c AND enable bit c. A line follows its register bits in the same cycle the register changes.
- R4: The per-type view uses word addresses: interrupt status at 0x0, interrupt enable at 0x4, transfer status at 0x8 and transfer enable at 0xC. Bit c of each word is channel c. Writing an enable word loads all enable bits of that type.
- R5: The per-channel word for channel c is at 0x100 + 4*c. Bit 0 is interrupt status, bit 1 is transfer status, bit 2 is interrupt enable and bit 3 is transfer enable; bits 31:4 read as 0. A write loads both enable bits of that channel from bits 2 and 3.
- R6: Status bits are write-1-to-clear in both views. Writing 0 to a status bit leaves it unchanged.
- R7: A DMA acknowledge on channel c clears that channel's transfer status bit and leaves the interrupt status bits unchanged.
- R8: When a set pulse and any clear (host write or DMA acknowledge) reach the same bit in the same cycle, the bit ends up 1.
- R9: While module-disable is high, set pulses are ignored, but host clears and DMA acknowledge clears still take effect.
- R10: A read (select high, write low) puts its data on the read-data port in the following cycle, and the read changes no state. The read-data port holds its value until the next read. Unmapped addresses and addresses whose two low bits are not 00 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| engDisable | input | 1 | Module disable; blocks set pulses |
| intSetPulse | input | NUM_CH | Per-channel interrupt set pulses from the engine |
| xferSetPulse | input | NUM_CH | Per-channel transfer set pulses from the engine |
| dmaAck | input | NUM_CH | Per-channel DMA completion acknowledges |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid the cycle after a read |
| intLine | output | NUM_CH | Gated interrupt request lines |
| xferLine | output | NUM_CH | Gated data-transfer request lines |

## Verification
The properties assume that no input is X after reset and that every input is 0 while reset is asserted. They also assume that a status bit can rise only after a set pulse seen in the previous cycle. The stimulus drives every input at the falling edge and returns it to idle after each access. During reads it never fires set pulses or acknowledges, so the no-side-effect property always has a quiet cycle to judge. Collisions between a set and a clear are created on purpose with a single combined bus-and-pulse step. Reads and writes go only to aligned or deliberately unaligned addresses inside the 12-bit space.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;
  // Width of the channel index carried in the strobe struct (up to 256 channels)
  localparam int CH_IDX_W = 8;

  // Bit positions within a per-channel word; the host decodes these
  localparam int PC_INT_STS  = 0;
  localparam int PC_XFER_STS = 1;
  localparam int PC_INT_EN   = 2;
  localparam int PC_XFER_EN  = 3;
  localparam int PC_W        = 4;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_INT_STS,
    TGT_INT_EN,
    TGT_XFER_STS,
    TGT_XFER_EN,
    TGT_CHAN
  } tgt_e;

  typedef struct packed {
    logic                wrIntSts;
    logic                wrIntEn;
    logic                wrXferSts;
    logic                wrXferEn;
    logic                wrChan;
    logic                rdStb;
    tgt_e                target;
    logic [CH_IDX_W-1:0] chanIdx;
  } ctrlStb_t;
endpackage

// File: rtl/irq_dma_decode.sv
module irq_dma_decode
  import irq_dma_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int ADDR_W    = 12,
  parameter int TYPE_BASE = 0,
  parameter int CHAN_BASE = 256
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStb_t          stb
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] WA_INT_STS  = WA_W'(TYPE_BASE / 4);
  localparam logic [WA_W-1:0] WA_INT_EN   = WA_W'(TYPE_BASE / 4 + 1);
  localparam logic [WA_W-1:0] WA_XFER_STS = WA_W'(TYPE_BASE / 4 + 2);
  localparam logic [WA_W-1:0] WA_XFER_EN  = WA_W'(TYPE_BASE / 4 + 3);
  localparam logic [WA_W-1:0] WA_CHAN_LO  = WA_W'(CHAN_BASE / 4);
  localparam logic [WA_W-1:0] WA_CHAN_HI  = WA_W'(CHAN_BASE / 4 + NUM_CH);

  logic [WA_W-1:0] wordAddr;
  logic [WA_W-1:0] chanOff;
  logic            aligned;
  tgt_e            target;
  logic            doWrite;

  assign wordAddr = busAddr[ADDR_W-1:2];
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign chanOff  = wordAddr - WA_CHAN_LO;
  assign doWrite  = busSel & busWr;

  always_comb begin
    target = TGT_NONE;
    if (busSel && aligned) begin
      if (wordAddr == WA_INT_STS)       target = TGT_INT_STS;
      else if (wordAddr == WA_INT_EN)   target = TGT_INT_EN;
      else if (wordAddr == WA_XFER_STS) target = TGT_XFER_STS;
      else if (wordAddr == WA_XFER_EN)  target = TGT_XFER_EN;
      else if (wordAddr >= WA_CHAN_LO && wordAddr < WA_CHAN_HI)
                                        target = TGT_CHAN;
    end
  end

  always_comb begin
    stb           = '0;
    stb.target    = target;
    stb.chanIdx   = CH_IDX_W'(chanOff);
    stb.rdStb     = busSel & ~busWr;
    stb.wrIntSts  = doWrite && (target == TGT_INT_STS);
    stb.wrIntEn   = doWrite && (target == TGT_INT_EN);
    stb.wrXferSts = doWrite && (target == TGT_XFER_STS);
    stb.wrXferEn  = doWrite && (target == TGT_XFER_EN);
    stb.wrChan    = doWrite && (target == TGT_CHAN);
  end
endmodule

// File: rtl/irq_dma_cell.sv
module irq_dma_cell #(
  parameter bit HAS_EXT_CLR = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic setPulse,
  input  logic hostClr,
  input  logic extClr,
  input  logic enWrite,
  input  logic enData,
  output logic sts,
  output logic en,
  output logic line
);
  logic clrAny;

  generate
    if (HAS_EXT_CLR) begin : g_ext
      assign clrAny = hostClr | extClr;
    end else begin : g_host
      assign clrAny = hostClr | (extClr & 1'b0);
    end
  endgenerate

  // Set has priority over every clear so no request is dropped
  always_ff @(posedge clk) begin
    if (!rstN)         sts <= 1'b0;
    else if (setPulse) sts <= 1'b1;
    else if (clrAny)   sts <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        en <= 1'b0;
    else if (enWrite) en <= enData;
  end

  assign line = sts & en;
endmodule

// File: rtl/irq_dma_datapath.sv
module irq_dma_datapath
  import irq_dma_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              engDisable,
  input  logic [NUM_CH-1:0] intSetPulse,
  input  logic [NUM_CH-1:0] xferSetPulse,
  input  logic [NUM_CH-1:0] dmaAck,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0] intSts,
  output logic [NUM_CH-1:0] xferSts,
  output logic [NUM_CH-1:0] intLine,
  output logic [NUM_CH-1:0] xferLine,
  output logic [DATA_W-1:0] busRdata
);
  logic [NUM_CH-1:0] intEn;
  logic [NUM_CH-1:0] xferEn;
  logic [NUM_CH-1:0] setGate;
  logic [PC_W-1:0]   chanWord;
  logic [DATA_W-1:0] rdNext;

  assign setGate = {NUM_CH{~engDisable}};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic chanHit;
    logic intHostClr;
    logic xferHostClr;
    logic intEnWr;
    logic xferEnWr;
    logic intEnData;
    logic xferEnData;

    assign chanHit     = stb.wrChan && (stb.chanIdx == CH_IDX_W'(ch));
    assign intHostClr  = (stb.wrIntSts & wdata[ch]) | (chanHit & wdata[PC_INT_STS]);
    assign xferHostClr = (stb.wrXferSts & wdata[ch]) | (chanHit & wdata[PC_XFER_STS]);
    assign intEnWr     = stb.wrIntEn | chanHit;
    assign xferEnWr    = stb.wrXferEn | chanHit;
    assign intEnData   = stb.wrIntEn ? wdata[ch] : wdata[PC_INT_EN];
    assign xferEnData  = stb.wrXferEn ? wdata[ch] : wdata[PC_XFER_EN];

    irq_dma_cell #(.HAS_EXT_CLR(1'b0)) u_int (
      .clk     (clk),
      .rstN    (rstN),
      .setPulse(intSetPulse[ch] & setGate[ch]),
      .hostClr (intHostClr),
      .extClr  (1'b0),
      .enWrite (intEnWr),
      .enData  (intEnData),
      .sts     (intSts[ch]),
      .en      (intEn[ch]),
      .line    (intLine[ch])
    );

    irq_dma_cell #(.HAS_EXT_CLR(1'b1)) u_xfer (
      .clk     (clk),
      .rstN    (rstN),
      .setPulse(xferSetPulse[ch] & setGate[ch]),
      .hostClr (xferHostClr),
      .extClr  (dmaAck[ch]),
      .enWrite (xferEnWr),
      .enData  (xferEnData),
      .sts     (xferSts[ch]),
      .en      (xferEn[ch]),
      .line    (xferLine[ch])
    );
  end

  always_comb begin
    chanWord = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (stb.chanIdx == CH_IDX_W'(c)) begin
        chanWord[PC_INT_STS]  = intSts[c];
        chanWord[PC_XFER_STS] = xferSts[c];
        chanWord[PC_INT_EN]   = intEn[c];
        chanWord[PC_XFER_EN]  = xferEn[c];
      end
    end
  end

  always_comb begin
    case (stb.target)
      TGT_INT_STS:  rdNext = DATA_W'(intSts);
      TGT_INT_EN:   rdNext = DATA_W'(intEn);
      TGT_XFER_STS: rdNext = DATA_W'(xferSts);
      TGT_XFER_EN:  rdNext = DATA_W'(xferEn);
      TGT_CHAN:     rdNext = DATA_W'(chanWord);
      default:      rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busRdata <= '0;
    else if (stb.rdStb) busRdata <= rdNext;
  end
endmodule

// File: rtl/irq_dma_req_unit.sv
module irq_dma_req_unit
  import irq_dma_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int TYPE_BASE = 0,
  parameter int CHAN_BASE = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              engDisable,
  input  logic [NUM_CH-1:0] intSetPulse,
  input  logic [NUM_CH-1:0] xferSetPulse,
  input  logic [NUM_CH-1:0] dmaAck,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] intLine,
  output logic [NUM_CH-1:0] xferLine
);
  if (NUM_CH > DATA_W || NUM_CH > (1 << CH_IDX_W)) begin : g_bad_cfg
    $error("NUM_CH does not fit the per-type word or the channel index");
  end

  ctrlStb_t          stb;
  logic [NUM_CH-1:0] intSts;
  logic [NUM_CH-1:0] xferSts;

  irq_dma_decode #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .TYPE_BASE(TYPE_BASE),
    .CHAN_BASE(CHAN_BASE)
  ) u_decode (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb)
  );

  irq_dma_datapath #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .engDisable  (engDisable),
    .intSetPulse (intSetPulse),
    .xferSetPulse(xferSetPulse),
    .dmaAck      (dmaAck),
    .stb         (stb),
    .wdata       (busWdata),
    .intSts      (intSts),
    .xferSts     (xferSts),
    .intLine     (intLine),
    .xferLine    (xferLine),
    .busRdata    (busRdata)
  );
endmodule

// File: rtl/irq_dma_req_chk.sv
module irq_dma_req_chk #(
  parameter int NUM_CH    = 32,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int TYPE_BASE = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              engDisable,
  input logic [NUM_CH-1:0] intSetPulse,
  input logic [NUM_CH-1:0] xferSetPulse,
  input logic [NUM_CH-1:0] dmaAck,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [NUM_CH-1:0] intLine,
  input logic [NUM_CH-1:0] xferLine,
  input logic [NUM_CH-1:0] intSts,
  input logic [NUM_CH-1:0] xferSts
);
  localparam logic [ADDR_W-1:0] A_INT_EN  = ADDR_W'(TYPE_BASE + 4);
  localparam logic [ADDR_W-1:0] A_XFER_EN = ADDR_W'(TYPE_BASE + 12);

  // R8
  int_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !engDisable |=> ((intSts & $past(intSetPulse)) == $past(intSetPulse)));

  // R8
  xfer_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !engDisable |=> ((xferSts & $past(xferSetPulse)) == $past(xferSetPulse)));

  // R2
  no_spurious_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((intSts & ~$past(intSts) & ~$past(intSetPulse)) == '0) &&
    ((xferSts & ~$past(xferSts) & ~$past(xferSetPulse)) == '0));

  // R9
  disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(engDisable) |-> (((intSts & ~$past(intSts)) == '0) &&
                           ((xferSts & ~$past(xferSts)) == '0)));

  // R7
  dma_ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferSts & $past(dmaAck) & ~$past(xferSetPulse & {NUM_CH{~engDisable}})) == '0);

  // R10
  read_no_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && intSetPulse == '0 && xferSetPulse == '0 && dmaAck == '0)
      |=> ($stable(intSts) && $stable(xferSts)));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWr) |=> $stable(busRdata));

  // R3
  int_gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == A_INT_EN && busWdata[NUM_CH-1:0] == '0)
      |=> (intLine == '0));

  // R3
  xfer_gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == A_XFER_EN && busWdata[NUM_CH-1:0] == '0)
      |=> (xferLine == '0));
endmodule

bind irq_dma_req_unit irq_dma_req_chk #(
  .NUM_CH   (NUM_CH),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .TYPE_BASE(TYPE_BASE)
) u_chk (.*);

// File: tb/sim_irq_dma_req_unit.sv
module sim_irq_dma_req_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            engDisable = 1'b0;
  logic [NCH-1:0]  intSetPulse = '0, xferSetPulse = '0, dmaAck = '0;
  logic            busSel = 1'b0, busWr = 1'b0;
  logic [11:0]     busAddr = '0;
  logic [31:0]     busWdata = '0;
  logic [31:0]     busRdata;
  logic [NCH-1:0]  intLine, xferLine;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Expected state, built from the requirements
  logic [NCH-1:0] mIntSts = '0, mXferSts = '0, mIntEn = '0, mXferEn = '0;
  logic [31:0]    lastRead = '0;

  typedef struct { logic [31:0] val; string tag; } expItem_t;
  expItem_t expQ[$];
  logic rdLatch = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dma_req_unit u0 (
    .clk(clk), .rstN(rstN), .engDisable(engDisable),
    .intSetPulse(intSetPulse), .xferSetPulse(xferSetPulse), .dmaAck(dmaAck),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .intLine(intLine), .xferLine(xferLine)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [11:0] a);
    logic [31:0] r;
    int c;
    r = '0;
    if (a[1:0] == 2'b00) begin
      if (a == 12'h000) r = mIntSts;
      else if (a == 12'h004) r = mIntEn;
      else if (a == 12'h008) r = mXferSts;
      else if (a == 12'h00C) r = mXferEn;
      else if (a >= 12'h100 && a < 12'h180) begin
        c = int'((a - 12'h100) >> 2);
        r = {28'd0, mXferEn[c], mIntEn[c], mXferSts[c], mIntSts[c]};
      end
    end
    return r;
  endfunction

  // Driver: one cycle of stimulus, called at a falling edge
  task automatic step(input logic [NCH-1:0] iSet, input logic [NCH-1:0] xSet,
                      input logic [NCH-1:0] ack, input logic sel, input logic wr,
                      input logic [11:0] a, input logic [31:0] d, input string tag);
    logic [NCH-1:0] gI, gX, clrI, clrX;
    int c;
    intSetPulse = iSet; xferSetPulse = xSet; dmaAck = ack;
    busSel = sel; busWr = wr; busAddr = a; busWdata = d;
    if (sel && !wr) begin
      expQ.push_back('{expRead(a), tag});
      lastRead = expRead(a);
    end
    gI = engDisable ? '0 : iSet;
    gX = engDisable ? '0 : xSet;
    clrI = '0; clrX = '0;
    if (sel && wr && a[1:0] == 2'b00) begin
      if (a == 12'h000) clrI = d;
      else if (a == 12'h004) mIntEn = d;
      else if (a == 12'h008) clrX = d;
      else if (a == 12'h00C) mXferEn = d;
      else if (a >= 12'h100 && a < 12'h180) begin
        c = int'((a - 12'h100) >> 2);
        clrI[c] = d[0]; clrX[c] = d[1]; mIntEn[c] = d[2]; mXferEn[c] = d[3];
      end
    end
    mIntSts  = gI | (mIntSts & ~clrI);
    mXferSts = gX | (mXferSts & ~(clrX | ack));
    @(negedge clk);
    intSetPulse = '0; xferSetPulse = '0; dmaAck = '0;
    busSel = 1'b0; busWr = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step('0, '0, '0, 1'b1, 1'b1, a, d, "");
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step('0, '0, '0, 1'b1, 1'b0, a, '0, tag);
  endtask

  task automatic pulse(input logic [NCH-1:0] i, input logic [NCH-1:0] x, input logic [NCH-1:0] k);
    step(i, x, k, 1'b0, 1'b0, '0, '0, "");
  endtask

  task automatic checkLines(input string tag);
    check(intLine == (mIntSts & mIntEn), {tag, " intLine"}, intLine, mIntSts & mIntEn);
    check(xferLine == (mXferSts & mXferEn), {tag, " xferLine"}, xferLine, mXferSts & mXferEn);
  endtask

  // Monitor: compare each read result the cycle after it was issued
  always @(posedge clk) rdLatch <= rstN && busSel && !busWr;

  always @(negedge clk) begin
    if (rdLatch) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected read data", busRdata, '0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(busRdata === it.val, it.tag, busRdata, it.val);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(busRdata == '0, "R1 rdata in reset", busRdata, '0);
    check(intLine == '0 && xferLine == '0, "R1 lines in reset", {intLine}, '0);
    rstN = 1'b1;
    @(negedge clk);
    rd(12'h000, "R1 int status after reset");
    rd(12'h004, "R1 int enable after reset");
    rd(12'h008, "R1 xfer status after reset");
    rd(12'h00C, "R1 xfer enable after reset");
    checkLines("R1");

    // R2: set pulses raise status, lines stay low with enables off
    pulse(32'h8000_0021, 32'h0000_0022, '0);
    rd(12'h000, "R2 int status set");
    rd(12'h008, "R2 xfer status set");
    checkLines("R3 enables off");
    // R2: status holds with no further pulses
    pulse('0, '0, '0);
    rd(12'h000, "R2 int status held");

    // R4: per-type enable write and gating
    wr(12'h004, 32'h0000_0021);
    checkLines("R3 int enabled");
    rd(12'h004, "R4 int enable readback");

    // R5: per-channel view
    rd(12'h114, "R5 channel 5 word");
    rd(12'h17C, "R5 channel 31 word");
    wr(12'h104, 32'h0000_0008);
    rd(12'h104, "R5 channel 1 word after enable write");
    rd(12'h00C, "R4 xfer enable via channel write");
    checkLines("R3 xfer ch1 enabled");

    // R6: write-1-to-clear, writing zeros does nothing
    wr(12'h000, 32'h0000_0001);
    rd(12'h000, "R6 per-type clear ch0");
    wr(12'h008, 32'h0000_0000);
    rd(12'h008, "R6 zero write keeps xfer status");
    wr(12'h114, 32'h0000_0005);
    rd(12'h114, "R6 per-channel clear ch5");
    rd(12'h000, "R6 int status after channel clear");
    checkLines("R6");

    // R7: DMA acknowledge clears transfer status only
    pulse(32'h0000_0002, 32'h0000_0028, '0);
    pulse('0, '0, 32'h0000_0022);
    rd(12'h008, "R7 xfer status after ack");
    rd(12'h000, "R7 int status untouched by ack");
    checkLines("R7");

    // R8: set and clear in the same cycle
    step(32'h0000_0080, '0, '0, 1'b1, 1'b1, 12'h000, 32'h0000_0080, "");
    rd(12'h000, "R8 int set beats host clear");
    step('0, 32'h0000_0010, 32'h0000_0010, 1'b0, 1'b0, '0, '0, "");
    rd(12'h008, "R8 xfer set beats dma ack");
    step('0, 32'h0000_0100, '0, 1'b1, 1'b1, 12'h120, 32'h0000_0002, "");
    rd(12'h120, "R8 xfer set beats channel clear");

    // R9: module disable blocks sets, clears still work
    engDisable = 1'b1;
    pulse(32'hFFFF_FFFF, 32'hFFFF_FFFF, '0);
    rd(12'h000, "R9 int sets ignored while disabled");
    rd(12'h008, "R9 xfer sets ignored while disabled");
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, "R9 host clear while disabled");
    pulse('0, '0, 32'hFFFF_FFFF);
    rd(12'h008, "R9 dma clear while disabled");
    engDisable = 1'b0;
    pulse(32'h0000_0400, '0, '0);
    rd(12'h000, "R9 sets resume after enable");

    // R10: unmapped and unaligned reads, no side effect, hold
    wr(12'h00C, 32'hFFFF_FFFF);
    pulse('0, 32'h0000_0008, '0);
    checkLines("R3 xfer ch3 line");
    wr(12'h180, 32'hFFFF_FFFF);
    wr(12'h002, 32'hFFFF_FFFF);
    rd(12'h000, "R10 unmapped and unaligned writes ignored");
    rd(12'h180, "R10 unmapped read");
    rd(12'h200, "R10 unmapped read high");
    rd(12'h002, "R10 unaligned read");
    rd(12'h008, "R10 read once");
    rd(12'h008, "R10 repeated read same value");
    pulse('0, '0, '0);
    pulse('0, '0, '0);
    check(busRdata == lastRead, "R10 rdata holds when idle", busRdata, lastRead);
    checkLines("R10");

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R10 all reads answered", expQ.size(), 0);
    finishRun();
  end
endmodule